// File: doc/BRIEF.md
# Serial Stereo Audio Output Formatter

This block turns stereo sample pairs into a bit-serial audio stream. It drives a free-running serial bit clock, a left/right word clock and a data line. Each stereo frame is 64 bit clocks long and holds two 32-bit channel slots, left first. Each word is sent most significant bit first in two's complement.

Three active-low select pins set the format. One pin chooses between a rear-justified layout and an I2S-style front-packed layout. The other two pins set the word length to 16, 18 or 20 bits. All timing comes from `bck_en`, a single-cycle enable in the system clock domain. Each pulse advances the serial bit clock by half a period.

At the first falling bit-clock edge of every frame, the block latches the parallel sample pair and the decoded format, and raises `pair_taken` for one system clock. The source can then present the next pair. Changes at other times have no effect until the next frame starts.

Top module: `aud_serial_fmt`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `sclk`, `sdata`, `wclk` and `pair_taken` are all 0.
- R2: `sclk` inverts on every clock where `bck_en` is 1 and holds its value on every clock where `bck_en` is 0. It keeps toggling across word and frame boundaries.
- R3: `sdata` and `wclk` change only on the clock where `sclk` goes from 1 to 0. They hold across rising edges and idle clocks.
- R4: A frame is 64 bit-clock periods: slot positions 0..31 carry the left channel and 32..63 the right channel. A bit-clock period starts at a falling edge of `sclk`.
- R5: Word length decode: `fmt_w20_n`=0 gives 20 bits whatever `fmt_w18_n` is; otherwise `fmt_w18_n`=0 gives 18 bits; both at 1 give 16 bits. The decode is the same in both layouts.
- R6: With `fmt_i2s_n`=1 (rear-justified), `wclk` is 1 during the left slot and 0 during the right. A W-bit word fills the last W positions of its slot, and the positions before it drive 0.
- R7: With `fmt_i2s_n`=0 (I2S-style), `wclk` is 0 during the left slot and 1 during the right. The MSB is at slot position 1, one bit clock after the `wclk` edge. The word fills positions 1..W, and position 0 and positions after the word drive 0.
- R8: The sample inputs are 20 bits wide. A W-bit word is made of input bits 19 down to 20-W, sent in that order, and the lower input bits are dropped.
- R9: The sample pair and the format pins are captured on the falling edge that starts slot position 0, and `pair_taken` is 1 for exactly that one clock. Values applied at any other time do not affect the frame in progress.
- R10: After reset, the first `bck_en` pulse makes a rising edge. The second makes the falling edge that starts a frame at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bck_en | input | 1 | Half-period advance strobe for the serial bit clock |
| left_in | input | 20 | Left-channel sample, two's complement |
| right_in | input | 20 | Right-channel sample, two's complement |
| fmt_i2s_n | input | 1 | Layout select: 0 I2S-style front-packed, 1 rear-justified |
| fmt_w20_n | input | 1 | Active-low 20-bit word select |
| fmt_w18_n | input | 1 | Active-low 18-bit word select |
| pair_taken | output | 1 | One-clock pulse when a new sample pair is captured |
| sclk | output | 1 | Serial bit clock |
| sdata | output | 1 | Serial data, changes on the falling edge of `sclk` |
| wclk | output | 1 | Left/right word clock |

## Verification
The bench sweeps all eight combinations of the three format pins, one frame each, then repeats the first combination. Every frame uses its own sample pair, so each bit position of both slots is compared against an arithmetic model. This separates the word length, the justification, the word-clock polarity and a one-bit misplacement of the MSB. The next frame's pins and samples are applied in the middle of the current frame, which shows whether capture waits for the frame boundary. Idle clocks between enable pulses, and the rising half of each bit period, show whether the clock and data hold still and change only on a falling edge.

// File: rtl/aud_fmt_pkg.sv
package aud_fmt_pkg;

  typedef enum logic [1:0] {
    WL16 = 2'd0,
    WL18 = 2'd1,
    WL20 = 2'd2
  } wlen_e;

  typedef struct packed {
    logic  i2s;   // 1: front-packed, word clock low on left
    wlen_e wlen;
  } fmt_t;

  function automatic int wlen_bits(wlen_e w);
    case (w)
      WL20:    return 20;
      WL18:    return 18;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/aud_fmt_decode.sv
module aud_fmt_decode
  import aud_fmt_pkg::*;
(
  input  logic i2s_n,
  input  logic w20_n,
  input  logic w18_n,
  output fmt_t fmt
);

  always_comb begin
    fmt.i2s = ~i2s_n;
    if (!w20_n)      fmt.wlen = WL20;
    else if (!w18_n) fmt.wlen = WL18;
    else             fmt.wlen = WL16;
  end

endmodule

// File: rtl/aud_bit_timer.sv
module aud_bit_timer #(
  parameter int FRAME_BITS = 64,
  localparam int CNT_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bck_en,
  output logic             sclk,
  output logic [CNT_W-1:0] nxt_pos,
  output logic             fall,
  output logic             frame_start
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0] pos_q;

  assign nxt_pos     = (pos_q == LAST) ? '0 : pos_q + 1'b1;
  assign fall        = bck_en & sclk;
  assign frame_start = fall & (nxt_pos == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk  <= 1'b0;
      pos_q <= LAST;
    end else if (bck_en) begin
      sclk <= ~sclk;
      if (sclk) pos_q <= nxt_pos;
    end
  end

endmodule

// File: rtl/aud_bit_select.sv
module aud_bit_select
  import aud_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int SLOT_W   = 32,
  localparam int SLOT_LG = $clog2(SLOT_W),
  localparam int CNT_W   = SLOT_LG + 1
) (
  input  logic [SAMPLE_W-1:0] left,
  input  logic [SAMPLE_W-1:0] right,
  input  fmt_t                fmt,
  input  logic [CNT_W-1:0]    pos,
  output logic                bit_o,
  output logic                wclk_o
);

  logic                ch;
  logic [SAMPLE_W-1:0] word;
  int                  p;
  int                  wl;
  int                  start;
  int                  k;

  always_comb begin
    ch     = pos[SLOT_LG];
    p      = int'(pos[SLOT_LG-1:0]);
    wl     = wlen_bits(fmt.wlen);
    start  = fmt.i2s ? 1 : (SLOT_W - wl);
    k      = p - start;
    word   = ch ? right : left;
    wclk_o = fmt.i2s ? ch : ~ch;
    bit_o  = 1'b0;
    for (int i = 0; i < SAMPLE_W; i++) begin
      if ((k == i) && (i < wl)) bit_o = word[SAMPLE_W-1-i];
    end
  end

endmodule

// File: rtl/aud_serial_fmt.sv
module aud_serial_fmt
  import aud_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int SLOT_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bck_en,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  input  logic                fmt_i2s_n,
  input  logic                fmt_w20_n,
  input  logic                fmt_w18_n,
  output logic                pair_taken,
  output logic                sclk,
  output logic                sdata,
  output logic                wclk
);

  localparam int FRAME_BITS = 2 * SLOT_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  fmt_t                fmt_pin, fmt_q, fmt_sel;
  logic [SAMPLE_W-1:0] left_q, right_q, left_sel, right_sel;
  logic [CNT_W-1:0]    nxt_pos;
  logic                fall, frame_start;
  logic                bit_nxt, wclk_nxt;

  aud_fmt_decode i_decode (
    .i2s_n (fmt_i2s_n),
    .w20_n (fmt_w20_n),
    .w18_n (fmt_w18_n),
    .fmt   (fmt_pin)
  );

  aud_bit_timer #(.FRAME_BITS(FRAME_BITS)) i_timer (
    .clk         (clk),
    .rst         (rst),
    .bck_en      (bck_en),
    .sclk        (sclk),
    .nxt_pos     (nxt_pos),
    .fall        (fall),
    .frame_start (frame_start)
  );

  // the first bit of a frame is built from the values being captured
  assign fmt_sel   = frame_start ? fmt_pin  : fmt_q;
  assign left_sel  = frame_start ? left_in  : left_q;
  assign right_sel = frame_start ? right_in : right_q;

  aud_bit_select #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) i_select (
    .left   (left_sel),
    .right  (right_sel),
    .fmt    (fmt_sel),
    .pos    (nxt_pos),
    .bit_o  (bit_nxt),
    .wclk_o (wclk_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q      <= '0;
      left_q     <= '0;
      right_q    <= '0;
      sdata      <= 1'b0;
      wclk       <= 1'b0;
      pair_taken <= 1'b0;
    end else begin
      pair_taken <= frame_start;
      if (frame_start) begin
        fmt_q   <= fmt_pin;
        left_q  <= left_in;
        right_q <= right_in;
      end
      if (fall) begin
        sdata <= bit_nxt;
        wclk  <= wclk_nxt;
      end
    end
  end

endmodule

// File: rtl/aud_serial_fmt_chk.sv
module aud_serial_fmt_chk (
  input logic clk,
  input logic rst,
  input logic bck_en,
  input logic pair_taken,
  input logic sclk,
  input logic sdata,
  input logic wclk
);

  AST_SCLK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bck_en |=> $stable(sclk)); // R2

  AST_SCLK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    bck_en |=> (sclk != $past(sclk))); // R2

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> $fell(sclk)); // R3

  AST_WCLK_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(wclk) |-> $fell(sclk)); // R3

  AST_TAKE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    pair_taken |-> $fell(sclk)); // R9

  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pair_taken |=> !pair_taken); // R9

endmodule

bind aud_serial_fmt aud_serial_fmt_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .bck_en     (bck_en),
  .pair_taken (pair_taken),
  .sclk       (sclk),
  .sdata      (sdata),
  .wclk       (wclk)
);

// File: tb/test_aud_serial_fmt.sv
module test_aud_serial_fmt;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bck_en = 1'b0;
  logic [19:0] left_in = '0;
  logic [19:0] right_in = '0;
  logic        fmt_i2s_n = 1'b1;
  logic        fmt_w20_n = 1'b1;
  logic        fmt_w18_n = 1'b1;
  logic        pair_taken, sclk, sdata, wclk;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;  // 125 MHz

  aud_serial_fmt i_aud_serial_fmt (
    .clk        (clk),
    .rst        (rst),
    .bck_en     (bck_en),
    .left_in    (left_in),
    .right_in   (right_in),
    .fmt_i2s_n  (fmt_i2s_n),
    .fmt_w20_n  (fmt_w20_n),
    .fmt_w18_n  (fmt_w18_n),
    .pair_taken (pair_taken),
    .sclk       (sclk),
    .sdata      (sdata),
    .wclk       (wclk)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // half bit-clock period: one enable clock, sampled at the following negedge
  task automatic half();
    bck_en = 1'b1;
    @(negedge clk);
    bck_en = 1'b0;
  endtask

  function automatic int wlen_of(input logic [2:0] c);
    if (!c[1])      return 20;
    else if (!c[0]) return 18;
    else            return 16;
  endfunction

  // c = {i2s_n, w20_n, w18_n}
  function automatic logic exp_bit(input logic [19:0] l, input logic [19:0] r,
                                   input logic [2:0] c, input int b);
    int wl, ch, p, st;
    logic [19:0] s;
    wl = wlen_of(c);
    ch = b / 32;
    p  = b % 32;
    s  = (ch == 1) ? r : l;
    st = c[2] ? (32 - wl) : 1;
    if (p >= st && p < st + wl) return s[19 - (p - st)];
    return 1'b0;
  endfunction

  function automatic logic exp_wclk(input logic [2:0] c, input int b);
    return c[2] ? (b < 32) : (b >= 32);
  endfunction

  initial begin
    logic [19:0] cur_l, cur_r, nxt_l, nxt_r;
    logic [2:0]  cur_c, nxt_c;
    logic        held;
    string       tag;

    repeat (3) @(negedge clk);
    check(sclk === 1'b0 && sdata === 1'b0 && wclk === 1'b0 && pair_taken === 1'b0,
          "R1 reset outputs", {sclk, sdata, wclk, pair_taken}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({sclk, sdata, wclk, pair_taken} === 4'b0, "R1 after release",
          {sclk, sdata, wclk, pair_taken}, 0);
    repeat (3) @(negedge clk);
    check(sclk === 1'b0, "R2 idle hold", sclk, 0);

    half();
    check(sclk === 1'b1, "R10 first pulse rises", sclk, 1);
    check(pair_taken === 1'b0, "R10 no capture on rise", pair_taken, 0);

    cur_c = 3'd0;
    cur_l = 20'hA5C3F;
    cur_r = 20'h3B18D;
    fmt_i2s_n = cur_c[2]; fmt_w20_n = cur_c[1]; fmt_w18_n = cur_c[0];
    left_in = cur_l; right_in = cur_r;

    for (int f = 0; f < 9; f++) begin
      nxt_c = 3'((f + 1) % 8);
      nxt_l = 20'h5A3C1 ^ 20'((f + 1) * 20'h12345);
      nxt_r = 20'hC96E7 ^ 20'((f + 1) * 20'h0F0F3);
      tag = cur_c[2] ? "R5 R6 R8" : "R5 R7 R8";
      for (int b = 0; b < 64; b++) begin
        half();
        check(sclk === 1'b0, "R2 falling", sclk, 0);
        check(sdata === exp_bit(cur_l, cur_r, cur_c, b), tag, sdata,
              exp_bit(cur_l, cur_r, cur_c, b));
        check(wclk === exp_wclk(cur_c, b), cur_c[2] ? "R4 R6 wclk" : "R4 R7 wclk",
              wclk, exp_wclk(cur_c, b));
        check(pair_taken === (b == 0), "R9 capture pulse", pair_taken, (b == 0));
        held = sdata;
        if (b == 12) begin
          // next frame's values arrive mid-frame and must wait for the boundary
          fmt_i2s_n = nxt_c[2]; fmt_w20_n = nxt_c[1]; fmt_w18_n = nxt_c[0];
          left_in = nxt_l; right_in = nxt_r;
        end
        half();
        check(sclk === 1'b1, "R2 rising", sclk, 1);
        check(sdata === held, "R3 hold on rise", sdata, held);
        check(pair_taken === 1'b0, "R9 pulse width", pair_taken, 0);
        if (b % 8 == 3) begin
          @(negedge clk);
          check(sclk === 1'b1 && sdata === held, "R2 R3 idle clock", {sclk, sdata}, {1'b1, held});
        end
      end
      cur_c = nxt_c; cur_l = nxt_l; cur_r = nxt_r;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule